// File: doc/BRIEF.md
# Sparse Tile Switch Matrix

This block is the routing switch box of one fabric tile. It owns a bus of local switch wires that it hands to the neighbouring tiles. Each switch wire comes from its own configurable multiplexer. The candidates for that multiplexer are a constant low, a constant high, one wire from each of the eight neighbour buses, and a small fixed subset of the tile's logic-cell outputs. In the other direction, every logic-cell input pin is driven by a multiplexer over a sparse, evenly strided subset of the switch wires.

The connection pattern is fixed and modular with a stride of 6. A pin or a cell output reaches only the switch wires whose index has the same remainder modulo 6 as its own index. The neighbour taps are rotated: from direction d, switch wire i takes neighbour wire (i + d) mod 56. All multiplexer selects sit in one serial configuration chain, which is loaded while `cfg_en` is high. After the chain is loaded, every route is purely combinational and needs no clock.

The block has no streaming data path. The configuration pins are plain control pins with no handshake. Shifting takes place on every clock edge where `cfg_en` is high, and the block never applies back-pressure.

Top module: `swm_tile_switch`

## Requirements
- R1: Reset clears the whole configuration chain. With the configuration cleared, every bit of `sw_out`, every bit of `pin_in` and `cfg_do` reads 0.
- R2: Each rising edge with `cfg_en` high shifts `cfg_di` into the top of the 352-bit chain, and `cfg_do` shows the bottom bit of the chain. After 352 shifts, the k-th bit shifted in is configuration bit k. On a reload, `cfg_do` therefore presents the old configuration bits in the order 0, 1, 2, ...
- R3: Rising edges with `cfg_en` low leave the configuration and all routes unchanged, whatever `cfg_di` does.
- R4: Switch wire i takes its 4-bit select from configuration bits 4i..4i+3, least significant bit first. Select 0 drives the wire to 0, and select 1 drives it to 1.
- R5: A wire select of 2+d, where d is 0..7 for directions N, NE, E, SE, S, SW, W, NW, drives switch wire i from `nb_in[d*56 + (i+d) mod 56]`.
- R6: A wire select of 10+k drives switch wire i from `logic_out[(i mod 6) + 6k]`, provided that index is below 16.
- R7: A wire select that names no candidate drives the wire to 0. This covers 13..15 for every wire, and 12 for wires with i mod 6 equal to 4 or 5.
- R8: Logic input pin p takes its 4-bit select k from configuration bits 224+4p..227+4p, least significant bit first. It is driven from `sw_out[(p mod 6) + 6k]` when that index is below 56, and otherwise it reads 0.
- R9: Once the block is configured, `sw_out` and `pin_in` follow changes on `nb_in` and `logic_out` within the same time step, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset of the configuration chain |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_di | input | 1 | Serial configuration input |
| cfg_do | output | 1 | Serial configuration output (bottom bit of the chain) |
| nb_in | input | 448 | Eight neighbour buses of 56 wires each; direction d occupies bits d*56 to d*56+55 |
| logic_out | input | 16 | Outputs of the tile's logic cells |
| sw_out | output | 56 | Local switch wires, sent on to the neighbouring tiles |
| pin_in | output | 32 | Drives the inputs of the tile's logic cells |

## Verification
Routing results depend on no register, so they are due in the same time step as a change on `nb_in` or `logic_out`. The bench changes those inputs at a falling edge and samples one time unit later, with no clock in between. A new configuration becomes visible right after the 352nd shift edge, so the checks run at the falling edge that follows the last shift. `cfg_do` is a register output: it is sampled at each falling edge before that edge's shift. The bit seen at the k-th sample is the old configuration bit k, and the bench compares it against the bits it loaded earlier.

// File: rtl/swm_pkg.sv
package swm_pkg;
  // Number of indices r, r+s, r+2s, ... that stay below lim.
  function automatic int stride_taps(input int r, input int lim, input int s);
    if (lim <= r) return 0;
    return (lim - r + s - 1) / s;
  endfunction
endpackage

// File: rtl/swm_cfg_chain.sv
module swm_cfg_chain #(
  parameter int BITS = 352
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            di,
  output logic            dout,
  output logic [BITS-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (en) q <= {di, q[BITS-1:1]};
  end

  assign dout = q[0];

  // R2: the bit leaving the chain is the one that sat next to the bottom
  p_shift_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (dout == $past(q[1])));
  p_top_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (q[BITS-1] == $past(di)));
  // R3: no shift, no change
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/swm_wire_mux.sv
module swm_wire_mux #(
  parameter int IDX     = 0,
  parameter int NUM_DIR = 8,
  parameter int NUM_OUT = 16,
  parameter int STRIDE  = 6,
  parameter int SELW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SELW-1:0]    sel,
  input  logic [NUM_DIR-1:0] nb_tap,
  input  logic [NUM_OUT-1:0] lo,
  output logic               sw
);
  localparam int RES   = IDX % STRIDE;
  localparam int NLO   = swm_pkg::stride_taps(RES, NUM_OUT, STRIDE);
  localparam int NCAND = 2 + NUM_DIR + NLO;
  localparam int NSLOT = 2 ** SELW;

  logic [NSLOT-1:0] cand;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    if (k == 0) begin : g_zero
      assign cand[k] = 1'b0;
    end else if (k == 1) begin : g_one
      assign cand[k] = 1'b1;
    end else if (k < 2 + NUM_DIR) begin : g_nb
      assign cand[k] = nb_tap[k-2];
    end else if (k < NCAND) begin : g_lo
      assign cand[k] = lo[RES + (k - 2 - NUM_DIR) * STRIDE];
    end else begin : g_none
      assign cand[k] = 1'b0;
    end
  end

  assign sw = cand[sel];

  // R7: a select beyond the candidate list gives 0
  p_wire_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) >= NCAND) |-> (sw == 1'b0));
  // R4: constant selects
  p_wire_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel < SELW'(2)) |-> (sw == sel[0]));
endmodule

// File: rtl/swm_pin_mux.sv
module swm_pin_mux #(
  parameter int IDX    = 0,
  parameter int NUM_SW = 56,
  parameter int STRIDE = 6,
  parameter int SELW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SELW-1:0]   sel,
  input  logic [NUM_SW-1:0] sw,
  output logic              pin
);
  localparam int RES   = IDX % STRIDE;
  localparam int NCAND = swm_pkg::stride_taps(RES, NUM_SW, STRIDE);
  localparam int NSLOT = 2 ** SELW;

  logic [NSLOT-1:0] cand;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    if (k < NCAND) begin : g_tap
      assign cand[k] = sw[RES + k * STRIDE];
    end else begin : g_none
      assign cand[k] = 1'b0;
    end
  end

  assign pin = cand[sel];

  // R8: a select past the last reachable wire gives 0
  p_pin_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) >= NCAND) |-> (pin == 1'b0));
  // R8: select 0 reaches the wire at the pin's own residue
  p_pin_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> (pin == sw[RES]));
endmodule

// File: rtl/swm_tile_switch.sv
module swm_tile_switch #(
  parameter int LUTS    = 8,
  parameter int LUT_K   = 4,
  parameter int SPARE   = 16,
  parameter int NUM_DIR = 8,
  parameter int STRIDE  = 6,
  parameter int NUM_SW  = LUTS * (LUT_K + 1) + SPARE,
  parameter int NUM_IN  = LUTS * LUT_K,
  parameter int NUM_OUT = 2 * LUTS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_en,
  input  logic                      cfg_di,
  output logic                      cfg_do,
  input  logic [NUM_DIR*NUM_SW-1:0] nb_in,
  input  logic [NUM_OUT-1:0]        logic_out,
  output logic [NUM_SW-1:0]         sw_out,
  output logic [NUM_IN-1:0]         pin_in
);
  localparam int WSEL     = $clog2(2 + NUM_DIR + (NUM_OUT + STRIDE - 1) / STRIDE);
  localparam int PSEL     = $clog2((NUM_SW + STRIDE - 1) / STRIDE);
  localparam int PIN_BASE = NUM_SW * WSEL;
  localparam int CFG_BITS = PIN_BASE + NUM_IN * PSEL;

  logic [CFG_BITS-1:0] cfg_q;

  swm_cfg_chain #(.BITS(CFG_BITS)) u_chain (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (cfg_en),
    .di   (cfg_di),
    .dout (cfg_do),
    .q    (cfg_q)
  );

  for (genvar i = 0; i < NUM_SW; i++) begin : g_wire
    logic [NUM_DIR-1:0] taps;
    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      assign taps[d] = nb_in[d*NUM_SW + ((i + d) % NUM_SW)];
    end
    swm_wire_mux #(
      .IDX(i), .NUM_DIR(NUM_DIR), .NUM_OUT(NUM_OUT), .STRIDE(STRIDE), .SELW(WSEL)
    ) u_mux (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (cfg_q[i*WSEL +: WSEL]),
      .nb_tap(taps),
      .lo    (logic_out),
      .sw    (sw_out[i])
    );
  end

  for (genvar p = 0; p < NUM_IN; p++) begin : g_pin
    swm_pin_mux #(
      .IDX(p), .NUM_SW(NUM_SW), .STRIDE(STRIDE), .SELW(PSEL)
    ) u_mux (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (cfg_q[PIN_BASE + p*PSEL +: PSEL]),
      .sw   (sw_out),
      .pin  (pin_in[p])
    );
  end

  // R1: the cycle after reset releases, with no shift yet, nothing is routed
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_n) && !cfg_en) |-> (sw_out == '0 && pin_in == '0));
  // R5: wire 0 with select 2 follows the north bus at index 0
  p_north_tap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[WSEL-1:0] == WSEL'(2)) |-> (sw_out[0] == nb_in[0]));
endmodule

// File: tb/tb_swm_tile_switch.sv
module tb_swm_tile_switch;
  localparam int NSW = 56, NIN = 32, NOUT = 16, NDIR = 8, CB = 352;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_di = 1'b0;
  logic cfg_do;
  logic [NDIR*NSW-1:0] nb_in = '0;
  logic [NOUT-1:0] logic_out = '0;
  logic [NSW-1:0] sw_out;
  logic [NIN-1:0] pin_in;

  int errs = 0, checks = 0;
  int wsel [NSW];
  int psel [NIN];
  logic [CB-1:0] loaded = '0;

  always #5 clk = ~clk;

  swm_tile_switch dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_di(cfg_di), .cfg_do(cfg_do),
    .nb_in(nb_in), .logic_out(logic_out), .sw_out(sw_out), .pin_in(pin_in)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NSW-1:0] exp_sw();
    logic [NSW-1:0] v;
    for (int i = 0; i < NSW; i++) begin
      int s = wsel[i];
      if (s == 0) v[i] = 1'b0;
      else if (s == 1) v[i] = 1'b1;
      else if (s < 10) v[i] = nb_in[(s-2)*NSW + (i + s - 2) % NSW];
      else begin
        int o = i % 6 + 6 * (s - 10);
        v[i] = (o < NOUT) ? logic_out[o] : 1'b0;
      end
    end
    return v;
  endfunction

  function automatic logic [NIN-1:0] exp_pin();
    logic [NSW-1:0] w = exp_sw();
    logic [NIN-1:0] v;
    for (int p = 0; p < NIN; p++) begin
      int j = p % 6 + 6 * psel[p];
      v[p] = (j < NSW) ? w[j] : 1'b0;
    end
    return v;
  endfunction

  function automatic logic [CB-1:0] pack();
    logic [CB-1:0] b;
    for (int i = 0; i < NSW; i++) b[i*4 +: 4] = 4'(wsel[i]);
    for (int p = 0; p < NIN; p++) b[224 + p*4 +: 4] = 4'(psel[p]);
    return b;
  endfunction

  // Shift the current wsel/psel in; optionally compare the old bits on cfg_do (R2)
  task automatic load(input bit watch);
    logic [CB-1:0] b = pack();
    int bad = 0;
    for (int k = 0; k < CB; k++) begin
      @(negedge clk);
      if (watch && cfg_do !== loaded[k]) bad++;
      cfg_en = 1'b1;
      cfg_di = b[k];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    loaded = b;
    if (watch) chk("R2 cfg_do order mismatches", 64'(bad), 64'd0);
    #1;
  endtask

  task automatic check_routes(input string req);
    chk({req, " sw_out"}, 64'(sw_out), 64'(exp_sw()));
    chk({req, " pin_in"}, 64'(pin_in), 64'(exp_pin()));
  endtask

  task automatic randomize_inputs();
    for (int w = 0; w < NDIR*NSW; w++) nb_in[w] = 1'($urandom);
    logic_out = 16'($urandom);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NSW; i++) wsel[i] = 0;
    for (int p = 0; p < NIN; p++) psel[p] = 0;
    randomize_inputs();
    #1;
    chk("R1 sw_out after reset", 64'(sw_out), 64'd0);
    chk("R1 pin_in after reset", 64'(pin_in), 64'd0);
    chk("R1 cfg_do after reset", 64'(cfg_do), 64'd0);
  endtask

  task automatic t_const();
    for (int i = 0; i < NSW; i++) wsel[i] = (i % 3 == 0) ? 1 : 0;
    for (int p = 0; p < NIN; p++) psel[p] = p % 10;
    load(1'b0);
    check_routes("R4 R8 constants");
  endtask

  task automatic t_neigh();
    for (int i = 0; i < NSW; i++) wsel[i] = 2 + (i % 8);
    for (int p = 0; p < NIN; p++) psel[p] = (p * 3) % 11;
    load(1'b1);
    check_routes("R5 neighbour taps");
    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      randomize_inputs();
      #1;
      check_routes("R9 R5 no-clock follow");
    end
  endtask

  task automatic t_lout();
    for (int i = 0; i < NSW; i++) wsel[i] = 10 + (i % 6);
    for (int p = 0; p < NIN; p++) psel[p] = 9 + (p % 7);
    load(1'b1);
    check_routes("R6 R7 R8 logic outputs and ranges");
    logic_out = ~logic_out;
    #1;
    check_routes("R6 R9 logic outputs toggled");
    for (int i = 0; i < NSW; i++) wsel[i] = 13 + (i % 3);
    load(1'b1);
    chk("R7 out-of-range wire selects", 64'(sw_out), 64'd0);
  endtask

  task automatic t_hold();
    logic [NSW-1:0] s0;
    logic [NIN-1:0] p0;
    for (int i = 0; i < NSW; i++) wsel[i] = (i * 7) % 16;
    for (int p = 0; p < NIN; p++) psel[p] = (p * 5) % 16;
    load(1'b1);
    check_routes("R3 R8 mixed config");
    s0 = sw_out;
    p0 = pin_in;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cfg_di = ~cfg_di;
    end
    #1;
    chk("R3 sw_out held with cfg_en low", 64'(sw_out), 64'(s0));
    chk("R3 pin_in held with cfg_en low", 64'(pin_in), 64'(p0));
    load(1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_const();
    t_neigh();
    t_lout();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule